// File: doc/BRIEF.md
# Sectioned Program Counter Next-Address Unit

This block holds the 24-bit program counter of a core whose 16-Mbyte linear program space is split into 64-Kbyte sections. A section is the range of addresses that share the top byte. A page is the range that shares the top two bytes. On every enabled clock the block takes an operation code together with its operands: an effective address, a relative displacement with an instruction length, a far address, or bytes popped from the stack. From these it forms the next program counter and registers it.

Near transfers keep the current section byte or add to it. Increments, relative branches and far transfers treat the whole 24-bit space as linear. A registered section-crossed flag reports whether the last update changed the section byte. This makes it easy to confirm that near calls and near returns stay inside their section.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `pc` is RESET_PC (default 0x008000) and `sect_cross` is 0.
- R2: Op code 0 (hold), and every code from 9 to 15, leaves `pc` unchanged and clears `sect_cross`.
- R3: Op code 1 (increment) loads pc+1 modulo 2^24, so 0xFFFFFF is followed by 0x000000.
- R4: Op code 2 (relative) loads pc + `instr_len` + the sign-extended 8-bit `rel_disp`, modulo 2^24, and may leave the section.
- R5: Op code 3 (near jump, direct) loads {pc[23:16], ea[15:0]}. Bit 16 of `ea` has no effect.
- R6: Op code 4 (near jump, indexed) loads ({pc[23:16],16'h0} + the 17-bit `ea`) modulo 2^24, so it may land in the next section; from section 0xFF it wraps to section 0x00.
- R7: Op code 5 (near call) loads {pc[23:16], ea[15:0]}, so the section byte is unchanged.
- R8: Op code 6 (near return) loads {pc[23:16], pop_hi, pop_lo}. `pop_ext` has no effect.
- R9: Op code 7 (far jump or far call) loads all 24 bits of `far_addr`.
- R10: Op code 8 (far return) loads {pop_ext, pop_hi, pop_lo}.
- R11: On each edge with `rst_n` high, `sect_cross` becomes 1 exactly when the new `pc[23:16]` differs from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| ea | input | 17 | Effective address or offset for near transfers |
| rel_disp | input | 8 | Signed relative displacement |
| instr_len | input | 3 | Length of the current instruction in bytes |
| far_addr | input | 24 | Extended 3-byte target |
| pop_ext | input | 8 | Popped section byte |
| pop_hi | input | 8 | Popped high byte |
| pop_lo | input | 8 | Popped low byte |
| pc | output | 24 | Program counter |
| sect_cross | output | 1 | Last update changed the section byte |

## Verification
The bench builds the unit with its default parameters: a 24-bit address, 16-bit section offset, 8-bit displacement and 3-bit length field. These widths make section 0xFF and address 0xFFFFFF reachable with ordinary operands. The wrap of an increment, an indexed jump that overflows into the next section, and a backward branch across a section boundary are all driven directly. A mix of random operations is then compared with a behavioural model on every clock.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int ADDR_W   = 24,
  parameter int OFF_W    = 16,
  parameter int REL_W    = 8,
  parameter int LEN_W    = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = 24'h008000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [OFF_W:0]    ea,
  input  logic [REL_W-1:0]  rel_disp,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [ADDR_W-1:0] far_addr,
  input  logic [ADDR_W-OFF_W-1:0] pop_ext,
  input  logic [7:0]        pop_hi,
  input  logic [7:0]        pop_lo,
  output logic [ADDR_W-1:0] pc,
  output logic              sect_cross
);
  localparam int SEC_W = ADDR_W - OFF_W;

  logic [SEC_W-1:0]  sec;
  logic [ADDR_W-1:0] sec_base, rel_sum, idx_sum, nxt;

  assign sec      = pc[ADDR_W-1:OFF_W];
  assign sec_base = {sec, {OFF_W{1'b0}}};
  assign rel_sum  = pc + ADDR_W'(instr_len)
                  + {{(ADDR_W-REL_W){rel_disp[REL_W-1]}}, rel_disp};
  assign idx_sum  = sec_base + {{(ADDR_W-OFF_W-1){1'b0}}, ea};

  always_comb begin
    case (op)
      4'd1:    nxt = pc + 1'b1;
      4'd2:    nxt = rel_sum;
      4'd3,
      4'd5:    nxt = {sec, ea[OFF_W-1:0]};
      4'd4:    nxt = idx_sum;
      4'd6:    nxt = {sec, pop_hi, pop_lo};
      4'd7:    nxt = far_addr;
      4'd8:    nxt = {pop_ext, pop_hi, pop_lo};
      default: nxt = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      sect_cross <= 1'b0;
    end else begin
      pc         <= nxt;
      sect_cross <= (nxt[ADDR_W-1:OFF_W] != sec);
    end
  end
endmodule

module pc_next_unit_chk #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op,
  input logic [OFF_W:0]    ea,
  input logic [ADDR_W-1:0] far_addr,
  input logic [ADDR_W-OFF_W-1:0] pop_ext,
  input logic [7:0]        pop_hi,
  input logic [7:0]        pop_lo,
  input logic [ADDR_W-1:0] pc,
  input logic              sect_cross
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0) |=> ($stable(pc) && !sect_cross));
  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd1) |=> (pc == ADDR_W'($past(pc) + 1)));
  assert_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd5) |=> (!sect_cross && pc[OFF_W-1:0] == $past(ea[OFF_W-1:0])));
  assert_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6) |=> (!sect_cross && pc[OFF_W-1:0] == {$past(pop_hi), $past(pop_lo)}));
  assert_far_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |=> (pc == $past(far_addr)));
  assert_retf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd8) |=> (pc == {$past(pop_ext), $past(pop_hi), $past(pop_lo)}));
  assert_cross_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sect_cross |-> (pc[ADDR_W-1:OFF_W] != $past(pc[ADDR_W-1:OFF_W])));
endmodule

bind pc_next_unit pc_next_unit_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .ea(ea), .far_addr(far_addr),
  .pop_ext(pop_ext), .pop_hi(pop_hi), .pop_lo(pop_lo),
  .pc(pc), .sect_cross(sect_cross));

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [16:0] ea = '0;
  logic [7:0]  rel_disp = '0;
  logic [2:0]  instr_len = '0;
  logic [23:0] far_addr = '0;
  logic [7:0]  pop_ext = '0, pop_hi = '0, pop_lo = '0;
  logic [23:0] pc;
  logic        sect_cross;

  int checks = 0, fails = 0;
  int mpc;
  bit mcross;

  always #2.5 clk = ~clk;

  pc_next_unit dut (.*);

  function automatic string tag(input int o);
    case (o)
      1: return "R3"; 2: return "R4"; 3: return "R5"; 4: return "R6";
      5: return "R7"; 6: return "R8"; 7: return "R9"; 8: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic compare(input string t);
    checks++;
    if (pc !== mpc[23:0]) begin
      fails++;
      $display("FAIL %s pc actual=%06h expected=%06h", t, pc, mpc[23:0]);
    end
    checks++;
    if (sect_cross !== mcross) begin
      fails++;
      $display("FAIL R11 (%s) sect_cross actual=%0b expected=%0b", t, sect_cross, mcross);
    end
  endtask

  task automatic step(input int o, input int e, input int d, input int l,
                      input int f, input int pe, input int ph, input int pl);
    int nx, sdisp;
    op = 4'(o); ea = 17'(e); rel_disp = 8'(d); instr_len = 3'(l);
    far_addr = 24'(f); pop_ext = 8'(pe); pop_hi = 8'(ph); pop_lo = 8'(pl);
    sdisp = (d & 8'hFF) >= 128 ? (d & 8'hFF) - 256 : (d & 8'hFF);
    case (o)
      1: nx = mpc + 1;
      2: nx = mpc + (l & 7) + sdisp;
      3, 5: nx = (mpc & 24'hFF0000) | (e & 24'h00FFFF);
      4: nx = (mpc & 24'hFF0000) + (e & 24'h1FFFF);
      6: nx = (mpc & 24'hFF0000) | ((ph & 8'hFF) << 8) | (pl & 8'hFF);
      7: nx = f;
      8: nx = ((pe & 8'hFF) << 16) | ((ph & 8'hFF) << 8) | (pl & 8'hFF);
      default: nx = mpc;
    endcase
    nx = nx & 24'hFFFFFF;
    mcross = (nx >> 16) != (mpc >> 16);
    mpc = nx;
    @(posedge clk);
    @(negedge clk);
    compare(tag(o));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mpc = 24'h008000; mcross = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    // R2 hold after reset, then R1 value still present
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R3 wrap at top of space
    step(7, 0, 0, 0, 24'hFFFFFF, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    // R6 indexed jump from section 0xFF overflows to section 0x00
    step(7, 0, 0, 0, 24'hFF1234, 0, 0, 0);
    step(4, 17'h1FFFF, 0, 0, 0, 0, 0, 0);
    // R6 indexed into next section
    step(4, 17'h10010, 0, 0, 0, 0, 0, 0);
    // R4 backward branch across section boundary
    step(7, 0, 0, 0, 24'h050001, 0, 0, 0);
    step(2, 0, 8'hF0, 2, 0, 0, 0, 0);
    // R4 forward branch across boundary
    step(7, 0, 0, 0, 24'h05FFF0, 0, 0, 0);
    step(2, 0, 8'h7F, 3, 0, 0, 0, 0);
    // R5 ignores ea bit 16; R7 near call at section edge
    step(3, 17'h1ABCD, 0, 0, 0, 0, 0, 0);
    step(7, 0, 0, 0, 24'h03FFFF, 0, 0, 0);
    step(5, 17'h1FFFF, 0, 0, 0, 0, 0, 0);
    // R8 near return ignores pop_ext; R10 far return uses it
    step(6, 0, 0, 0, 0, 8'hEE, 8'h12, 8'h34);
    step(8, 0, 0, 0, 0, 8'hEE, 8'h12, 8'h34);
    // R2 unused codes hold
    step(9, 17'h1FFFF, 8'h80, 7, 24'hABCDEF, 1, 2, 3);
    step(15, 0, 0, 0, 24'h111111, 4, 5, 6);
    // R9 far, then R3 sequential inside section
    step(7, 0, 0, 0, 24'h7F00FE, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++)
      step(int'($urandom_range(0, 15)), int'($urandom), int'($urandom),
           int'($urandom), int'($urandom), int'($urandom), int'($urandom),
           int'($urandom));
    // R1 reset mid-run
    rst_n = 1'b0; mpc = 24'h008000; mcross = 0;
    @(posedge clk); @(negedge clk);
    compare("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule